// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing front end of a byte-addressed serial memory. It oversamples the two-wire clock and data lines with the system clock and finds START, repeated START and STOP conditions. It shifts in a device select byte and answers only when that byte carries the fixed device type nibble and the three board strap values. After a write-direction select it takes a two-byte memory address. It then either buffers incoming data bytes for one row of the array, or streams array bytes back to the master with an auto-incrementing address counter.

Writes go into a row buffer first. The buffered bytes reach the internal array only when a STOP ends the write on a byte boundary. A copy engine then moves the buffered bytes into the array, one buffer slot per system clock, over 2^PAGE_BITS cycles. The master is expected to leave the bus idle for that time. A write-lock input, sampled from START to the end of the address, turns a write into a no-op.

The only data path is the two-wire bus, which has no valid/ready handshake. The pace is set by the master's clock edges. The slave never holds off the master: a byte it cannot take gets no acknowledge, and it does not stretch the clock. The data line is modelled as open drain: the block only ever asks for the line to be pulled low. The array holds 2^ADDR_BITS bytes. ADDR_BITS = 14 gives the 16K-byte build and 15 gives the 32K-byte build; the default of 11 keeps elaboration small.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the block does not pull the data line low, and it ignores bus traffic until a START condition.
- R2: A select byte (most significant bit first) is acknowledged, by pulling data low during the 9th clock, only when bits 7..4 are 1010 and bits 3..1 equal chip_strap[2:0]. Bit 0 = 1 selects a read and bit 0 = 0 selects a write. On a mismatch nothing is acknowledged, including later bytes, until the next START. The slave changes the data line only while the clock is low.
- R3: After a write select, the slave takes the high address byte and then the low address byte, and acknowledges each one.
- R4: Address bits at positions ADDR_BITS and above have no effect on which array byte is accessed.
- R5: If write_lock is high at any sampled cycle from START through the end of the low address byte, the data bytes that follow are not acknowledged and the array is unchanged. A high level that appears only after that window has no effect.
- R6: A byte write (select, address, one data byte, STOP) stores the byte at the addressed location.
- R7: In a write, the low PAGE_BITS address bits advance after each data byte and wrap within the row, while the upper bits stay fixed. Bytes beyond 2^PAGE_BITS overwrite the earliest slots.
- R8: A random read (dummy write of select and address, repeated START, read select) returns the addressed byte. A current-address read (a read select straight after START) returns the byte at the internal address counter.
- R9: In a read, every master acknowledge requests one more byte. The counter advances after each byte and rolls over from the top of the array to 0.
- R10: Buffered write data reaches the array only on a STOP that falls on a byte boundary. A STOP in the middle of a byte, or any START, discards the buffered bytes.
- R11: After the master answers a read byte with no acknowledge, the slave releases the data line and stays idle until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_scl | input | 1 | Serial clock line as seen on the bus |
| bus_sda_in | input | 1 | Serial data line as seen on the bus |
| bus_sda_low | output | 1 | 1 = pull the data line low, 0 = release it |
| chip_strap | input | 3 | Board strap value the select byte must match |
| write_lock | input | 1 | 1 = block writes for the current transaction |

## Verification
On every cycle, the embedded assertions check four things. The data line only moves while the clock is low. An idle slave never pulls the line. A locked write never acknowledges a data byte. The row bits of the address stay fixed for the whole of a write.

Only the bench scenarios can show what actually lands in the array and how the address counter advances. They cover row wrap and overwrite beyond one row, rollover at the top of the array, and the discard of buffered bytes on a mid-byte STOP or a repeated START. They also show the lock window that closes at the end of the address, the ignored high address bits, and select-code mismatches on both the type nibble and the strap field.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA
  } ee_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, sda_m, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      sda_m <= 1'b1;
      scl_s <= 1'b1;
      sda_s <= 1'b1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= scl_raw;
      sda_m <= sda_raw;
      scl_s <= scl_m;
      sda_s <= sda_m;
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_BITS = 6,
  parameter int ROW_BITS  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_i,
  input  logic                          wr_i,
  input  logic [PAGE_BITS-1:0]          wr_off_i,
  input  logic [7:0]                    wr_data_i,
  input  logic                          commit_i,
  input  logic [ROW_BITS-1:0]           row_i,
  output logic                          mem_we_o,
  output logic [ROW_BITS+PAGE_BITS-1:0] mem_addr_o,
  output logic [7:0]                    mem_data_o
);
  localparam int DEPTH = 1 << PAGE_BITS;

  logic [7:0]           slot_q [DEPTH];
  logic [DEPTH-1:0]     full_q;
  logic                 busy_q;
  logic [PAGE_BITS-1:0] idx_q;
  logic [ROW_BITS-1:0]  row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      row_q  <= '0;
    end else if (busy_q) begin
      full_q[idx_q] <= 1'b0;
      idx_q         <= idx_q + 1'b1;
      if (idx_q == PAGE_BITS'(DEPTH - 1)) busy_q <= 1'b0;
    end else if (commit_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      row_q  <= row_i;
    end else if (clear_i) begin
      full_q <= '0;
    end else if (wr_i) begin
      full_q[wr_off_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i && !busy_q) slot_q[wr_off_i] <= wr_data_i;
  end

  assign mem_we_o   = busy_q & full_q[idx_q];
  assign mem_addr_o = {row_q, idx_q};
  assign mem_data_o = slot_q[idx_q];
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_BITS = 11
) (
  input  logic                 clk,
  input  logic                 we_i,
  input  logic [ADDR_BITS-1:0] waddr_i,
  input  logic [7:0]           wdata_i,
  input  logic [ADDR_BITS-1:0] raddr_i,
  output logic [7:0]           rdata_o
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_slave_pkg::*;
#(
  parameter int ADDR_BITS = 11,
  parameter int PAGE_BITS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_scl,
  input  logic       bus_sda_in,
  output logic       bus_sda_low,
  input  logic [2:0] chip_strap,
  input  logic       write_lock
);
  localparam int ROW_BITS = ADDR_BITS - PAGE_BITS;
  localparam int HI_BITS  = ADDR_BITS - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_raw  (bus_scl),
    .sda_raw  (bus_sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  ee_state_e            state_q;
  logic [3:0]           bitcnt_q;
  logic [7:0]           shreg_q;
  logic [7:0]           tx_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic [HI_BITS-1:0]   addr_hi_q;
  logic                 lock_q;
  logic                 rd_dir_q;
  logic                 m_ack_q;
  logic                 sda_low_q;

  logic                 byte_done, ack_end, sel_match;
  logic                 buf_wr, buf_clear, commit;
  logic [7:0]           rd_data;
  logic                 mem_we;
  logic [ADDR_BITS-1:0] mem_waddr;
  logic [7:0]           mem_wdata;

  assign byte_done = scl_fall && (bitcnt_q == 4'd8);
  assign ack_end   = scl_fall && (bitcnt_q == 4'd9);
  assign sel_match = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3:1] == chip_strap);
  assign buf_wr    = (state_q == ST_WDATA) && byte_done && !lock_q && !start_det && !stop_det;
  assign commit    = stop_det && (state_q == ST_WDATA) && (bitcnt_q <= 4'd1);
  assign buf_clear = start_det || (stop_det && !commit);

  eeprom_page_buf #(.PAGE_BITS(PAGE_BITS), .ROW_BITS(ROW_BITS)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (buf_clear),
    .wr_i      (buf_wr),
    .wr_off_i  (addr_q[PAGE_BITS-1:0]),
    .wr_data_i (shreg_q),
    .commit_i  (commit),
    .row_i     (addr_q[ADDR_BITS-1:PAGE_BITS]),
    .mem_we_o  (mem_we),
    .mem_addr_o(mem_waddr),
    .mem_data_o(mem_wdata)
  );

  eeprom_array #(.ADDR_BITS(ADDR_BITS)) u_array (
    .clk    (clk),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(addr_q),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      addr_hi_q <= '0;
      lock_q    <= 1'b0;
      rd_dir_q  <= 1'b0;
      m_ack_q   <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      // lock window: from START until the low address byte is finished
      if (write_lock && (state_q == ST_DEVSEL || state_q == ST_ADDR_HI ||
                         state_q == ST_ADDR_LO))
        lock_q <= 1'b1;

      if (start_det) begin
        state_q   <= ST_DEVSEL;
        bitcnt_q  <= '0;
        sda_low_q <= 1'b0;
        lock_q    <= write_lock;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        bitcnt_q  <= '0;
        sda_low_q <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: ;
          ST_RDATA: begin
            if (scl_rise) begin
              if (bitcnt_q < 4'd8) bitcnt_q <= bitcnt_q + 1'b1;
              else if (bitcnt_q == 4'd9) m_ack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (bitcnt_q == 4'd8) begin
                sda_low_q <= 1'b0;
                bitcnt_q  <= 4'd9;
                addr_q    <= addr_q + 1'b1;
              end else if (bitcnt_q == 4'd9) begin
                if (m_ack_q) begin
                  tx_q      <= rd_data;
                  sda_low_q <= ~rd_data[7];
                  bitcnt_q  <= '0;
                end else begin
                  state_q   <= ST_IDLE;
                  sda_low_q <= 1'b0;
                  bitcnt_q  <= '0;
                end
              end else if (bitcnt_q != 4'd0) begin
                tx_q      <= tx_q << 1;
                sda_low_q <= ~tx_q[6];
              end
            end
          end
          default: begin
            if (scl_rise && bitcnt_q < 4'd8) begin
              shreg_q  <= {shreg_q[6:0], sda_s};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (byte_done) begin
              bitcnt_q <= 4'd9;
              case (state_q)
                ST_DEVSEL: begin
                  rd_dir_q <= shreg_q[0];
                  if (sel_match) sda_low_q <= 1'b1;
                  else begin
                    state_q  <= ST_IDLE;
                    bitcnt_q <= '0;
                  end
                end
                ST_ADDR_HI: begin
                  sda_low_q <= 1'b1;
                  addr_hi_q <= shreg_q[HI_BITS-1:0];
                end
                ST_ADDR_LO: begin
                  sda_low_q <= 1'b1;
                  addr_q    <= {addr_hi_q, shreg_q};
                end
                default: begin
                  if (!lock_q) begin
                    sda_low_q <= 1'b1;
                    addr_q    <= {addr_q[ADDR_BITS-1:PAGE_BITS],
                                  addr_q[PAGE_BITS-1:0] + 1'b1};
                  end
                end
              endcase
            end else if (ack_end) begin
              sda_low_q <= 1'b0;
              bitcnt_q  <= '0;
              case (state_q)
                ST_DEVSEL: begin
                  if (rd_dir_q) begin
                    state_q   <= ST_RDATA;
                    tx_q      <= rd_data;
                    sda_low_q <= ~rd_data[7];
                    m_ack_q   <= 1'b0;
                  end else begin
                    state_q <= ST_ADDR_HI;
                  end
                end
                ST_ADDR_HI: state_q <= ST_ADDR_LO;
                ST_ADDR_LO: state_q <= ST_WDATA;
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end

  assign bus_sda_low = sda_low_q;

  // R2: the slave moves the data line only while the clock is low
  assert_sda_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_low_q));

  // R11 / R1: an idle slave never pulls the line
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_low_q);

  // R5: a locked write acknowledges no data byte
  assert_lock_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WDATA && lock_q) |-> !sda_low_q);

  // R7: the row part of the address stays fixed through a write
  assert_row_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WDATA && $past(state_q) == ST_WDATA)
      |-> $stable(addr_q[ADDR_BITS-1:PAGE_BITS]));
endmodule

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;
  localparam int ADDR_BITS = 11;
  localparam int PAGE_BITS = 6;
  localparam int Q = 5;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  localparam int MASK = (1 << ADDR_BITS) - 1;
  localparam int ROWM = (1 << PAGE_BITS) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic lock = 1'b0;
  logic sda_low;
  logic sda_line;

  assign sda_line = sda_m & ~sda_low;

  always #5 clk = ~clk;

  serial_eeprom_slave #(.ADDR_BITS(ADDR_BITS), .PAGE_BITS(PAGE_BITS)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_scl    (scl_m),
    .bus_sda_in (sda_line),
    .bus_sda_low(sda_low),
    .chip_strap (STRAP),
    .write_lock (lock)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [0:MASK];
  int ptr = 0;

  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (got_q.size() != 0);
      chk(tag_q.pop_front(), int'(got_q.pop_front()), int'(exp_q.pop_front()));
    end
  end

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b1; hq();
    repeat (100) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hq();
    scl_m = 1'b1; hq(); hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    ack = ~sda_line; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hq();
      scl_m = 1'b1; hq();
      d = {d[6:0], sda_line}; hq();
      scl_m = 1'b0; hq();
    end
    sda_m = ~mack; hq();
    scl_m = 1'b1; hq(); hq();
    scl_m = 1'b0; hq();
    sda_m = 1'b1;
  endtask

  task automatic addr_phase(input logic [15:0] a, input string tag);
    logic ack;
    bus_start();
    wbyte(DEV_W, ack); chk({tag, " R2 select ack"}, ack, 1);
    wbyte(a[15:8], ack); chk({tag, " R3 addr hi ack"}, ack, 1);
    wbyte(a[7:0], ack);  chk({tag, " R3 addr lo ack"}, ack, 1);
  endtask

  // write n bytes base+i starting at a, updating the model per R7
  task automatic wr_seq(input logic [15:0] a, input int n, input logic [7:0] base,
                        input string tag);
    logic ack;
    int phys, row;
    addr_phase(a, tag);
    phys = int'(a) & MASK;
    row  = phys & ~ROWM;
    for (int i = 0; i < n; i++) begin
      wbyte(base + 8'(i), ack);
      chk({tag, " R6 data ack"}, ack, 1);
      model[row | ((phys + i) & ROWM)] = base + 8'(i);
    end
    ptr = row | ((phys + n) & ROWM);
    bus_stop();
  endtask

  task automatic read_n(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[(ptr + i) & MASK]);
      tag_q.push_back(tag);
      rbyte(i != n - 1, d);
      got_q.push_back(d);
    end
    ptr = (ptr + n) & MASK;
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string tag);
    logic ack;
    addr_phase(a, tag);
    bus_start();
    wbyte(DEV_R, ack); chk({tag, " R8 read select ack"}, ack, 1);
    ptr = int'(a) & MASK;
    read_n(n, tag);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 line released after reset", sda_low, 0);

    // R2 mismatches: strap field, then type nibble
    bus_start();
    wbyte({4'b1010, 3'b100, 1'b0}, ack); chk("R2 strap mismatch nack", ack, 0);
    wbyte(8'h00, ack); chk("R2 ignored until START", ack, 0);
    bus_stop();
    bus_start();
    wbyte({4'b1011, STRAP, 1'b0}, ack); chk("R2 type mismatch nack", ack, 0);
    bus_stop();

    // R6 byte write, R8 random read
    wr_seq(16'h0123, 1, 8'h5A, "R6 byte write");
    rand_read(16'h0123, 1, "R8 random read");
    hq(); hq();
    chk("R11 released after master nack", sda_low, 0);

    // R4 high address bits ignored
    wr_seq(16'hF805, 1, 8'hC3, "R4 high bits");
    rand_read(16'h0005, 1, "R4 alias read");

    // R5 lock from START, lock raised only inside address, lock after window
    lock = 1'b1;
    addr_phase(16'h0123, "R5 lock at start");
    lock = 1'b0;
    wbyte(8'h77, ack); chk("R5 locked data nack", ack, 0);
    bus_stop();
    bus_start();
    wbyte(DEV_W, ack);
    lock = 1'b1;
    wbyte(8'h01, ack);
    lock = 1'b0;
    wbyte(8'h23, ack);
    wbyte(8'h78, ack); chk("R5 lock in addr window nack", ack, 0);
    bus_stop();
    rand_read(16'h0123, 1, "R5 array unchanged");
    addr_phase(16'h0124, "R5 late lock");
    lock = 1'b1;
    wbyte(8'h66, ack); chk("R5 lock after window still acked", ack, 1);
    bus_stop();
    lock = 1'b0;
    model[12'h124] = 8'h66;
    rand_read(16'h0124, 1, "R5 late lock stored");

    // R7 wrap inside the row
    wr_seq(16'h003E, 4, 8'h11, "R7 row wrap");
    rand_read(16'h003E, 2, "R7 row end");
    rand_read(16'h0000, 2, "R7 row start");

    // R7 overflow overwrites earliest, R9 sequential read of full row
    wr_seq(16'h0200, 66, 8'h80, "R7 overflow");
    rand_read(16'h0200, 64, "R9 sequential row read");

    // R8 current address read
    rand_read(16'h0123, 1, "R8 random before current");
    bus_start();
    wbyte(DEV_R, ack); chk("R8 current select ack", ack, 1);
    read_n(1, "R8 current address read");
    bus_stop();

    // R9 rollover at top of array
    wr_seq(16'h07FF, 1, 8'hEE, "R9 top byte");
    rand_read(16'h07FF, 2, "R9 rollover read");

    // R10 STOP mid byte aborts
    addr_phase(16'h0123, "R10 mid-byte stop");
    wbyte(8'h99, ack); chk("R10 data ack", ack, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    rand_read(16'h0123, 1, "R10 mid-byte stop discarded");

    // R10 repeated START discards
    addr_phase(16'h0124, "R10 restart");
    wbyte(8'h55, ack); chk("R10 restart data ack", ack, 1);
    rand_read(16'h0124, 1, "R10 restart discarded");

    wait (got_q.size() == 0);
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule